// File: doc/BRIEF.md
# Paged EEPROM Write and Read Controller

This block stands behind a two-wire serial slave front end and manages a byte array. The front end decodes the bus conditions and hands it one-cycle events. There is one event when a slave address byte has matched. It carries the read/write flag and three high address bits. There is one event for each byte received in a write transaction, one for each byte the bus master is about to read, and one for each STOP. The controller keeps the internal address pointer. In a write transaction the first received byte loads the pointer. The following bytes go into a page buffer, and that buffer is programmed into the array when the STOP arrives.

While a program cycle runs, the controller raises `busy` for a parameterised number of clock cycles and ignores every event. The front end uses `busy` to withhold its acknowledge, so a host can poll until the cycle ends. Reads are served from the pointer, and the whole pointer advances after each byte. A random read is a write transaction that sends only the byte address, followed by a repeated START for a read. When the protect input is high, the upper half of the array cannot be programmed, although the bus transaction still runs normally.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset `busy` and `rdValid` are low, and every array byte reads as 0.
- R2: In a write transaction, the first byte after the address event loads the pointer with `{addrHi, rxData}`, truncated to the array address width.
- R3: Each later byte in a write transaction is stored in the page buffer at the slot given by the low 4 pointer bits. Those bits then increment modulo 16 and the upper bits stay fixed. A 17th byte overwrites the first slot.
- R4: A STOP that ends a write transaction with at least one data byte programs the buffered bytes into the page selected by the pointer's upper bits. `busy` goes high on the following cycle and stays high for exactly WRITE_CYCLES cycles.
- R5: A STOP after only the byte address, or after no byte at all, programs nothing and leaves `busy` low.
- R6: While `busy` is high, address, byte, STOP and read events have no effect. A read request gives no `rdValid`, and a later read shows that the pointer is unchanged.
- R7: In a read transaction each `rdReq` returns the byte at the pointer and increments the full pointer. The pointer wraps from the top address to 0 and crosses page boundaries.
- R8: After a page write the pointer is one past the last byte stored, wrapping within the page, so an immediate read returns that location.
- R9: A write transaction that ends its address byte with a repeated START for a read returns data starting at the address that was sent.
- R10: With `wpIn` high at commit, bytes whose address has its MSB set are not programmed. The transaction is still accepted and `busy` still runs.
- R11: For arrays larger than 256 bytes, `addrHi` supplies the address bits above bit 7 and selects a different location than the same byte address with `addrHi` = 0.
- R12: `rdValid` is a one-cycle pulse on the cycle after an accepted `rdReq`, and `rdData` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addrValid | input | 1 | Slave address byte matched (START or repeated START) |
| addrRead | input | 1 | Read/write flag of that address byte, 1 = read |
| addrHi | input | 3 | High address bits carried in the slave address byte |
| rxValid | input | 1 | A byte was received in a write transaction |
| rxData | input | 8 | Received byte |
| stopEv | input | 1 | STOP condition seen |
| rdReq | input | 1 | Front end needs the next read byte |
| wpIn | input | 1 | Upper-half write protect |
| busy | output | 1 | Program cycle in progress |
| rdValid | output | 1 | `rdData` holds a fresh byte |
| rdData | output | 8 | Byte read from the array |

## Verification
The program-cycle timer can end in the same cycle that the front end delivers a new address event. That event falls in the last busy cycle and must be dropped; an address event one cycle later is accepted. The bench provokes this by counting WRITE_CYCLES-1 cycles after the STOP and then issuing a read address. It judges the outcome by the absence of `rdValid` on the next read request, and then by a normal read after a fresh address event. The cycle reference model agrees with this at every clock.

// File: rtl/eeprom_page_pkg.sv
package eeprom_page_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GETADDR,
    PH_GETDATA,
    PH_HAVEDATA,
    PH_READ
  } phase_t;

  typedef struct packed {
    logic clearPage;
    logic loadPtr;
    logic storeByte;
    logic commit;
    logic readByte;
  } strobe_t;
endpackage

// File: rtl/eeprom_page_ctrl_fsm.sv
module eeprom_page_ctrl_fsm
  import eeprom_page_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    addrValid,
  input  logic    addrRead,
  input  logic    rxValid,
  input  logic    stopEv,
  input  logic    rdReq,
  output strobe_t strb,
  output logic    busy
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  phase_t           phase, phaseNext;
  logic [CNT_W-1:0] cycleCnt;

  assign busy = (cycleCnt != '0);

  always_comb begin
    strb      = '0;
    phaseNext = phase;
    if (!busy) begin
      if (addrValid) begin
        strb.clearPage = 1'b1;
        phaseNext      = addrRead ? PH_READ : PH_GETADDR;
      end else if (stopEv) begin
        strb.commit = (phase == PH_HAVEDATA);
        phaseNext   = PH_IDLE;
      end else if (rxValid) begin
        if (phase == PH_GETADDR) begin
          strb.loadPtr = 1'b1;
          phaseNext    = PH_GETDATA;
        end else if (phase == PH_GETDATA || phase == PH_HAVEDATA) begin
          strb.storeByte = 1'b1;
          phaseNext      = PH_HAVEDATA;
        end
      end else if (rdReq && phase == PH_READ) begin
        strb.readByte = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cycleCnt <= '0;
    end else begin
      phase <= phaseNext;
      if (strb.commit) cycleCnt <= CNT_W'(WRITE_CYCLES);
      else if (busy)   cycleCnt <= cycleCnt - 1'b1;
    end
  end

  // R4: busy can only begin right after a STOP
  assert_busy_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stopEv));

  // R6: no action is taken while programming
  assert_quiet_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (strb == '0));

  assert_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));
endmodule

// File: rtl/eeprom_page_datapath.sv
module eeprom_page_datapath
  import eeprom_page_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  strobe_t    strb,
  input  logic [2:0] addrHi,
  input  logic [7:0] rxData,
  input  logic       wpIn,
  output logic       rdValid,
  output logic [7:0] rdData
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int UP_W   = ADDR_W - PAGE_W;

  logic [7:0]            mem     [MEM_BYTES];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageMask;
  logic [ADDR_W-1:0]     ptr;
  logic [2:0]            hiLat;

  wire [UP_W-1:0]   ptrUp = ptr[ADDR_W-1:PAGE_W];
  wire [PAGE_W-1:0] ptrLo = ptr[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      hiLat    <= '0;
      pageMask <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
      for (int a = 0; a < MEM_BYTES; a++) mem[a] <= '0;
      for (int s = 0; s < PAGE_BYTES; s++) pageBuf[s] <= '0;
    end else begin
      rdValid <= strb.readByte;
      if (strb.clearPage) begin
        pageMask <= '0;
        hiLat    <= addrHi;
      end
      if (strb.loadPtr) ptr <= ADDR_W'({hiLat, rxData});
      if (strb.storeByte) begin
        pageBuf[ptrLo]  <= rxData;
        pageMask[ptrLo] <= 1'b1;
        ptr             <= {ptrUp, PAGE_W'(ptrLo + 1'b1)};
      end
      if (strb.readByte) begin
        rdData <= mem[ptr];
        ptr    <= ptr + 1'b1;
      end
      if (strb.commit) begin
        for (int s = 0; s < PAGE_BYTES; s++) begin
          if (pageMask[s] && !(wpIn && ptrUp[UP_W-1]))
            mem[{ptrUp, PAGE_W'(s)}] <= pageBuf[s];
        end
        pageMask <= '0;
      end
    end
  end

  // R3: a page byte moves only the in-page bits
  assert_page_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.storeByte |=> (ptrUp == $past(ptrUp)) &&
                       (ptrLo == PAGE_W'($past(ptrLo) + 1'b1)));

  // R7: reads advance the whole pointer
  assert_read_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.readByte |=> ptr == ADDR_W'($past(ptr) + 1'b1));

  // R12: read data appears on the following cycle
  assert_rdvalid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> $past(strb.readByte));
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
  import eeprom_page_pkg::*;
#(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addrValid,
  input  logic       addrRead,
  input  logic [2:0] addrHi,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       stopEv,
  input  logic       rdReq,
  input  logic       wpIn,
  output logic       busy,
  output logic       rdValid,
  output logic [7:0] rdData
);
  strobe_t strb;

  eeprom_page_ctrl_fsm #(.WRITE_CYCLES(WRITE_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .addrValid(addrValid), .addrRead(addrRead),
    .rxValid(rxValid), .stopEv(stopEv), .rdReq(rdReq), .strb(strb), .busy(busy)
  );

  eeprom_page_datapath #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .addrHi(addrHi), .rxData(rxData),
    .wpIn(wpIn), .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: tb/tb_eeprom_page_ctrl.sv
`timescale 1ns/1ps
module tb_eeprom_page_ctrl;
  localparam int MEM = 512;
  localparam int WC  = 20;

  logic clk = 0, rst_n = 0;
  logic addrValid = 0, addrRead = 0, rxValid = 0, stopEv = 0, rdReq = 0, wpIn = 0;
  logic [2:0] addrHi = 0;
  logic [7:0] rxData = 0;
  logic busy, rdValid;
  logic [7:0] rdData;

  int checks = 0, errors = 0;

  eeprom_page_ctrl #(.MEM_BYTES(MEM), .PAGE_BYTES(16), .WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .addrValid(addrValid), .addrRead(addrRead),
    .addrHi(addrHi), .rxValid(rxValid), .rxData(rxData), .stopEv(stopEv),
    .rdReq(rdReq), .wpIn(wpIn), .busy(busy), .rdValid(rdValid), .rdData(rdData)
  );

  always #2.5 clk = ~clk;

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  int mm [MEM];
  int mbd [16];
  bit mbv [16];
  int mptr, mph, mhi, mcnt, mrd;
  bit mrv;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mm[a]) mm[a] = 0;
      foreach (mbv[s]) mbv[s] = 0;
      mptr = 0; mph = 0; mhi = 0; mcnt = 0; mrd = 0; mrv = 0;
    end else begin
      mrv = 0;
      if (mcnt > 0) mcnt--;
      else if (addrValid) begin
        foreach (mbv[s]) mbv[s] = 0;
        mhi = addrHi;
        mph = addrRead ? 4 : 1;
      end else if (stopEv) begin
        if (mph == 3) begin
          for (int s = 0; s < 16; s++) begin
            int a;
            a = (mptr / 16) * 16 + s;
            if (mbv[s] && !(wpIn && a >= MEM / 2)) mm[a] = mbd[s];
            mbv[s] = 0;
          end
          mcnt = WC;
        end
        mph = 0;
      end else if (rxValid) begin
        if (mph == 1) begin
          mptr = (mhi * 256 + rxData) % MEM;
          mph = 2;
        end else if (mph == 2 || mph == 3) begin
          int sl;
          sl = mptr % 16;
          mbd[sl] = rxData; mbv[sl] = 1;
          mptr = (mptr / 16) * 16 + (sl + 1) % 16;
          mph = 3;
        end
      end else if (rdReq && mph == 4) begin
        mrd = mm[mptr]; mrv = 1;
        mptr = (mptr + 1) % MEM;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    check("R4 busy vs model", busy, mcnt != 0);
    check("R12 rdValid vs model", rdValid, mrv);
    if (mrv) check("R7 rdData vs model", rdData, mrd);
  end

  task automatic sendAddr(int hi, bit rd);
    addrValid = 1; addrHi = 3'(hi); addrRead = rd;
    @(negedge clk); addrValid = 0;
  endtask
  task automatic sendByte(int b);
    rxValid = 1; rxData = 8'(b);
    @(negedge clk); rxValid = 0;
  endtask
  task automatic sendStop();
    stopEv = 1;
    @(negedge clk); stopEv = 0;
  endtask
  task automatic readOne(output int got, output bit vld);
    rdReq = 1;
    @(negedge clk); rdReq = 0;
    got = rdData; vld = rdValid;
  endtask
  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask
  task automatic randRead(int hi, int b);
    sendAddr(hi, 0); sendByte(b); sendAddr(hi, 1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int got, n; bit v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 rdValid after reset", rdValid, 0);

    // R2/R4 byte write
    sendAddr(0, 0); sendByte(8'h10); sendByte(8'hA5); sendStop();
    check("R4 busy starts", busy, 1);
    n = 0;
    while (busy) begin @(negedge clk); n++; end
    check("R4 busy length", n, WC);

    // R8 immediate read lands one past
    sendAddr(0, 1); readOne(got, v);
    check("R8 immediate read valid", v, 1);
    check("R8 immediate read data (0x11)", got, 0);
    // R9 random read
    randRead(0, 8'h10); readOne(got, v);
    check("R9 random read data", got, 8'hA5);
    check("R12 rdValid pulse", v, 1);
    @(negedge clk);
    check("R12 rdValid single cycle", rdValid, 0);
    sendStop();

    // R3 page wrap with overflow
    sendAddr(0, 0); sendByte(8'h2E);
    for (int k = 1; k <= 18; k++) sendByte(k);
    sendStop(); waitIdle();
    randRead(0, 8'h2D);
    readOne(got, v); check("R3 slot 2D", got, 8'h10);
    readOne(got, v); check("R3 overwritten slot 2E", got, 8'h11);
    readOne(got, v); check("R3 overwritten slot 2F", got, 8'h12);
    readOne(got, v); check("R7 read crosses page to 30", got, 0);
    sendStop();
    randRead(0, 8'h20); readOne(got, v); check("R3 wrapped slot 20", got, 3);
    sendStop();

    // R5 address only
    sendAddr(0, 0); sendByte(8'h40); sendStop();
    check("R5 no busy", busy, 0);
    @(negedge clk);
    check("R5 still no busy", busy, 0);

    // R10 / R11 protect in the upper half
    wpIn = 1;
    sendAddr(1, 0); sendByte(8'h05); sendByte(8'h77); sendStop();
    check("R10 busy despite protect", busy, 1);
    waitIdle(); wpIn = 0;
    randRead(1, 8'h05); readOne(got, v); check("R10 protected byte unchanged", got, 0);
    sendStop();
    sendAddr(1, 0); sendByte(8'h05); sendByte(8'h77); sendStop(); waitIdle();
    randRead(1, 8'h05); readOne(got, v); check("R11 high byte written", got, 8'h77);
    sendStop();
    randRead(0, 8'h05); readOne(got, v); check("R11 low alias distinct", got, 0);
    sendStop();

    // R7 full wrap
    randRead(1, 8'hFF); readOne(got, v); readOne(got, v);
    check("R7 wrap to 0", got, 0);
    sendStop();

    // R6 ignored while busy, plus last-busy-cycle collision
    sendAddr(0, 0); sendByte(8'h50); sendByte(8'h3C); sendStop();
    sendAddr(0, 1); readOne(got, v);
    check("R6 read ignored while busy", v, 0);
    waitIdle();
    sendAddr(0, 0); sendByte(8'h50); sendByte(8'h3D); sendStop();
    repeat (WC - 1) @(negedge clk);
    check("R4 busy in last cycle", busy, 1);
    sendAddr(0, 1); readOne(got, v);
    check("R6 address in last busy cycle dropped", v, 0);
    sendAddr(0, 1); readOne(got, v);
    check("R6 pointer unchanged, reads 0x51", got, 0);
    check("R6 read accepted after busy", v, 1);
    sendStop();

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule